// File: doc/BRIEF.md
# Frame-Based Sensor Sample FIFO

This block buffers motion-sensor sample frames between the sensor datapath and a host that drains them one byte at a time from a single data register. Each strobe on `smp_valid` stores one frame. The frame holds three 16-bit axis samples. A 2-bit axis-select setting decides how the host sees a frame. In three-axis mode a frame is six bytes. In single-axis mode it is two bytes of the chosen axis. Storage and fill level are counted in frames, and the depth in frames does not depend on the mode.

The host side gives a byte-read strobe and a transaction-end pulse, which stands in for the end of a serial burst. If a transaction ends partway through a frame, the rest of that frame is thrown away, so the next transaction starts on a frame boundary. Reading an empty FIFO returns zero bytes.

The block reports:
- the number of stored frames;
- a sticky overrun flag;
- a full interrupt;
- a watermark interrupt against a programmable level.

A write to either configuration input (axis select or watermark level) empties the buffer and clears the flags.

Top module: `accel_frame_fifo`

## Requirements
- R1: `axis_sel_val` encoding: 00 = all three axes, 01 = X only, 10 = Y only, 11 = Z only. In the all-axes mode a frame is read as six bytes in the order X[7:0], X[15:8], Y[7:0], Y[15:8], Z[7:0], Z[15:8].
- R2: In a single-axis mode a frame is read as two bytes of the selected axis, bits [7:0] first and then bits [15:8]. The other two samples of the frame are never output.
- R3: The FIFO holds 32 frames in every mode. `full_irq` is 1 exactly while `frame_cnt` equals 32.
- R4: A frame offered while `frame_cnt` is 32 is dropped. The stored frames and their order are unchanged, and `overrun` becomes 1 on the next cycle.
- R5: `overrun` stays 1 while frames are read out, including after `frame_cnt` reaches 0. Only a configuration write clears it.
- R6: A cycle with `axis_sel_wr` or `lvl_wr` high empties the FIFO. On the next cycle `frame_cnt`, `overrun`, `full_irq` and `wm_irq` reflect an empty buffer. A frame offered in that same cycle is dropped. `axis_sel_wr` loads the mode and `lvl_wr` loads the watermark level.
- R7: A `rd_done` pulse that arrives after some but not all bytes of a frame have been read removes that frame. The next byte read is byte 0 of the following frame. A `rd_done` pulse that arrives on a frame boundary has no effect.
- R8: While `frame_cnt` is 0, `rd_byte` is 0x00, and byte reads and `rd_done` change no state.
- R9: `frame_cnt` always equals the number of complete frames stored. A push and a frame-completing read in the same cycle leave it unchanged.
- R10: `wm_irq` is 1 exactly while `frame_cnt` is greater than or equal to the programmed level.
- R11: After reset the FIFO is empty, `overrun` is 0, the mode is 00 and the watermark level is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Push one sample frame |
| smp_x | input | 16 | X-axis sample |
| smp_y | input | 16 | Y-axis sample |
| smp_z | input | 16 | Z-axis sample |
| axis_sel_wr | input | 1 | Write the axis-select setting (clears the FIFO) |
| axis_sel_val | input | 2 | New axis-select value |
| lvl_wr | input | 1 | Write the watermark level (clears the FIFO) |
| lvl_val | input | 6 | New watermark level in frames |
| rd_stb | input | 1 | Host reads one byte this cycle |
| rd_done | input | 1 | Host read transaction ends this cycle |
| rd_byte | output | 8 | Byte presented to the host (combinational from state) |
| frame_cnt | output | 6 | Number of stored frames |
| overrun | output | 1 | Sticky overrun flag |
| full_irq | output | 1 | FIFO full interrupt |
| wm_irq | output | 1 | Watermark interrupt |

## Verification
The hardest state to reach from the ports is a full FIFO that is pushed again and then drained to zero, with the overrun flag still set. Getting there takes 33 pushes with no reads in between, followed by 64 byte reads in a single-axis mode. The bench drives that sequence as a directed block. Partial-frame discard is also reached by directed steps: a transaction ends after three of six bytes, and in another case a transaction end coincides with the last byte of a frame. A long random phase with rare configuration writes then mixes pushes, reads and transaction ends against the queue model.

// File: rtl/accel_fifo_pkg.sv
// Package: shared types and widths for the frame FIFO.
// Assumes each axis sample is 16 bits and every frame slot holds all three axes.
package accel_fifo_pkg;
    localparam int AXIS_W  = 16;
    localparam int LANES   = 3;
    localparam int FRAME_W = AXIS_W * LANES;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        AXES_XYZ = 2'b00,
        AXIS_X   = 2'b01,
        AXIS_Y   = 2'b10,
        AXIS_Z   = 2'b11
    } axis_mode_e;

    typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/accel_frame_store.sv
// Frame store: circular buffer of DEPTH frame slots with a frame counter.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
// A push while full is refused; clr has priority over push and pop.
module accel_frame_store
    import accel_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  frame_t        push_frame,
    input  logic          pop,
    output frame_t        head_frame,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    frame_t        mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;

    assign full       = (count == CW'(DEPTH));
    assign empty      = (count == '0);
    assign push_ok    = push && !full && !clr;
    assign head_frame = mem[rd_ptr];

    // Write the incoming frame into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_frame;
    end

    // Advance the pointers and the frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop)     rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop);
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));
    // R6
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    // R9
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !clr) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/accel_frame_reader.sv
// Byte reader: walks the bytes of the head frame for the selected axis mode.
// It requests a pop when a frame is completed, or when a transaction ends
// partway through a frame. Outputs zero while the store is empty.
module accel_frame_reader
    import accel_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  axis_mode_e        mode,
    input  logic              rd_stb,
    input  logic              rd_done,
    input  logic              empty,
    input  frame_t            head_frame,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              pop
);
    logic [2:0]        bidx;
    logic [2:0]        last_idx;
    logic [1:0]        lane_sel;
    logic [AXIS_W-1:0] lane_val [LANES];
    logic [AXIS_W-1:0] sel_val;
    logic              adv;

    // Split the head frame into per-axis lanes (X lowest).
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_val[g] = head_frame[g*AXIS_W +: AXIS_W];
    end

    // Pick the lane and the last byte index for the current mode.
    always_comb begin
        if (mode == AXES_XYZ) begin
            last_idx = 3'd5;
            lane_sel = bidx[2:1];
        end else begin
            last_idx = 3'd1;
            lane_sel = 2'(mode) - 2'd1;
        end
        sel_val = lane_val[lane_sel];
    end

    // Present the selected byte, or zero when nothing is stored.
    always_comb begin
        if (empty)        rd_byte = '0;
        else if (bidx[0]) rd_byte = sel_val[15:8];
        else              rd_byte = sel_val[7:0];
    end

    assign adv = rd_stb && !empty;
    assign pop = !empty && !clr &&
                 ((rd_stb && bidx == last_idx) || (rd_done && (rd_stb || bidx != '0)));

    // Track the byte position inside the head frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) bidx <= '0;
        else if (pop)      bidx <= '0;
        else if (adv)      bidx <= bidx + 3'd1;
    end

    // R7
    end_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (bidx == '0));
    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != AXES_XYZ) |-> (bidx <= 3'd1));
    // R8
    empty_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !clr) |=> $stable(bidx));
endmodule

// File: rtl/accel_frame_fifo.sv
// Top: frame FIFO with axis-mode select, watermark level, sticky overrun
// and interrupt flags. Either configuration write empties the buffer.
// Assumes one sample frame per smp_valid pulse and one byte per rd_stb.
module accel_frame_fifo
    import accel_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [15:0]       smp_x,
    input  logic [15:0]       smp_y,
    input  logic [15:0]       smp_z,
    input  logic              axis_sel_wr,
    input  logic [1:0]        axis_sel_val,
    input  logic              lvl_wr,
    input  logic [CW-1:0]     lvl_val,
    input  logic              rd_stb,
    input  logic              rd_done,
    output logic [7:0]        rd_byte,
    output logic [CW-1:0]     frame_cnt,
    output logic              overrun,
    output logic              full_irq,
    output logic              wm_irq
);
    axis_mode_e    mode;
    logic [CW-1:0] wm_lvl;
    logic          clr;
    logic          pop;
    logic          full;
    logic          empty;
    frame_t        head_frame;

    assign clr = axis_sel_wr || lvl_wr;

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= AXES_XYZ;
            wm_lvl <= CW'(DEPTH);
        end else begin
            if (axis_sel_wr) mode   <= axis_mode_e'(axis_sel_val);
            if (lvl_wr)      wm_lvl <= lvl_val;
        end
    end

    // Set overrun on a refused push; only configuration writes clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)           overrun <= 1'b0;
        else if (smp_valid && full)  overrun <= 1'b1;
    end

    accel_frame_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .push       (smp_valid),
        .push_frame ({smp_z, smp_y, smp_x}),
        .pop        (pop),
        .head_frame (head_frame),
        .count      (frame_cnt),
        .full       (full),
        .empty      (empty)
    );

    accel_frame_reader u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .mode       (mode),
        .rd_stb     (rd_stb),
        .rd_done    (rd_done),
        .empty      (empty),
        .head_frame (head_frame),
        .rd_byte    (rd_byte),
        .pop        (pop)
    );

    assign full_irq = full;
    assign wm_irq   = (frame_cnt >= wm_lvl);

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr) |=> overrun);
    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && full_irq && !clr) |=> overrun);
    // R6
    clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!overrun && !full_irq));
endmodule

// File: tb/tb_accel_frame_fifo.sv
// Bench: queue-based reference model compared against the DUT on every clock.
module tb_accel_frame_fifo;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid, axis_sel_wr, lvl_wr, rd_stb, rd_done;
    logic [15:0] smp_x, smp_y, smp_z;
    logic [1:0]  axis_sel_val;
    logic [5:0]  lvl_val;
    logic [7:0]  rd_byte;
    logic [5:0]  frame_cnt;
    logic        overrun, full_irq, wm_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    bit [47:0] q[$];
    int m_mode, m_lvl, m_bidx;
    bit m_ovr;

    always #10 clk = ~clk;

    accel_frame_fifo dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_x(smp_x),
        .smp_y(smp_y), .smp_z(smp_z), .axis_sel_wr(axis_sel_wr),
        .axis_sel_val(axis_sel_val), .lvl_wr(lvl_wr), .lvl_val(lvl_val),
        .rd_stb(rd_stb), .rd_done(rd_done), .rd_byte(rd_byte),
        .frame_cnt(frame_cnt), .overrun(overrun), .full_irq(full_irq),
        .wm_irq(wm_irq)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_byte();
        int lane;
        if (q.size() == 0) return 0;
        if (m_mode == 0) return int'(q[0][m_bidx*8 +: 8]);
        lane = m_mode - 1;
        return int'(q[0][lane*16 + m_bidx*8 +: 8]);
    endfunction

    task automatic model_step();
        int last;
        bit was_full;
        was_full = (q.size() == 32);
        last = (m_mode == 0) ? 5 : 1;
        if (axis_sel_wr || lvl_wr) begin
            q.delete();
            m_bidx = 0;
            m_ovr = 0;
            if (axis_sel_wr) m_mode = int'(axis_sel_val);
            if (lvl_wr) m_lvl = int'(lvl_val);
        end else begin
            if (q.size() > 0) begin
                if (rd_stb && m_bidx == last) begin
                    void'(q.pop_front()); m_bidx = 0;
                end else if (rd_stb) begin
                    m_bidx++;
                    if (rd_done) begin void'(q.pop_front()); m_bidx = 0; end
                end else if (rd_done && m_bidx != 0) begin
                    void'(q.pop_front()); m_bidx = 0;
                end
            end
            if (smp_valid) begin
                if (was_full) m_ovr = 1;
                else q.push_back({smp_z, smp_y, smp_x});
            end
        end
    endtask

    task automatic cyc(string tag);
        #1;
        chk("R9 frame_cnt", int'(frame_cnt), q.size());
        chk("R5 overrun", int'(overrun), int'(m_ovr));
        chk("R3 full_irq", int'(full_irq), int'(q.size() == 32));
        chk("R10 wm_irq", int'(wm_irq), int'(q.size() >= m_lvl));
        chk({tag, " rd_byte"}, int'(rd_byte), exp_byte());
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic clear_in();
        smp_valid = 0; axis_sel_wr = 0; lvl_wr = 0; rd_stb = 0; rd_done = 0;
    endtask

    task automatic push(int x, int y, int z, string tag);
        smp_valid = 1; smp_x = 16'(x); smp_y = 16'(y); smp_z = 16'(z);
        cyc(tag); clear_in();
    endtask

    task automatic rd(string tag, bit fin);
        rd_stb = 1; rd_done = fin; cyc(tag); clear_in();
    endtask

    task automatic endrd(string tag);
        rd_done = 1; cyc(tag); clear_in();
    endtask

    task automatic set_mode(int m);
        axis_sel_wr = 1; axis_sel_val = 2'(m); cyc("R6"); clear_in();
    endtask

    task automatic set_lvl(int l);
        lvl_wr = 1; lvl_val = 6'(l); cyc("R6"); clear_in();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        clear_in();
        smp_x = 0; smp_y = 0; smp_z = 0; axis_sel_val = 0; lvl_val = 0;
        rst_n = 0;
        m_mode = 0; m_lvl = 32; m_bidx = 0; m_ovr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R11 reset state
        chk("R11 count", int'(frame_cnt), 0);
        chk("R11 overrun", int'(overrun), 0);
        chk("R11 wm_irq", int'(wm_irq), 0);
        chk("R11 rd_byte", int'(rd_byte), 0);

        // R8 empty reads return zero and change nothing
        rd("R8", 0); rd("R8", 1); endrd("R8");

        // R1 three-axis byte order
        push(16'h1201, 16'h3423, 16'h5645, "R1");
        push(16'hA1B2, 16'hC3D4, 16'hE5F6, "R1");
        push(16'h0F1E, 16'h2D3C, 16'h4B5A, "R1");
        for (int i = 0; i < 6; i++) rd("R1", 0);
        // R7 partial frame dropped on transaction end
        for (int i = 0; i < 3; i++) rd("R7", 0);
        endrd("R7");
        chk("R7 next frame byte0", int'(rd_byte), 16'h1E);
        rd("R7", 0);
        rd("R7", 1);
        endrd("R8");

        // R2 single-axis modes
        for (int m = 1; m < 4; m++) begin
            set_mode(m);
            push(16'h1122, 16'h3344, 16'h5566, "R2");
            push(16'h7788, 16'h99AA, 16'hBBCC, "R2");
            for (int i = 0; i < 4; i++) rd("R2", 0);
            rd("R8", 0);
        end

        // R3 R4 fill in single-axis mode, then overflow
        set_mode(3);
        for (int i = 0; i < 32; i++) push(i, i + 100, i + 200, "R3");
        chk("R3 full", int'(full_irq), 1);
        push(16'hDEAD, 16'hBEEF, 16'hCAFE, "R4");
        chk("R4 overrun set", int'(overrun), 1);
        chk("R4 count held", int'(frame_cnt), 32);
        // R5 drain all; overrun stays set
        for (int i = 0; i < 64; i++) rd("R4", 0);
        chk("R5 overrun after drain", int'(overrun), 1);
        chk("R5 count zero", int'(frame_cnt), 0);
        // R6 config write clears
        set_lvl(3);
        chk("R6 overrun cleared", int'(overrun), 0);

        // R10 watermark threshold
        for (int i = 0; i < 4; i++) push(i, i, i, "R10");
        chk("R10 wm set", int'(wm_irq), 1);
        // R9 push with frame-completing pop keeps count
        rd("R9", 0);
        smp_valid = 1; rd_stb = 1; cyc("R9"); clear_in();
        chk("R9 count kept", int'(frame_cnt), 4);
        // R6 push in the clearing cycle is dropped
        smp_valid = 1; axis_sel_wr = 1; axis_sel_val = 0; cyc("R6"); clear_in();
        chk("R6 cleared count", int'(frame_cnt), 0);
        chk("R6 wm cleared", int'(wm_irq), 0);

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            smp_valid = ($urandom_range(0, 99) < 55);
            smp_x = 16'($urandom); smp_y = 16'($urandom); smp_z = 16'($urandom);
            rd_stb = ($urandom_range(0, 99) < 45);
            rd_done = ($urandom_range(0, 99) < 12);
            axis_sel_wr = ($urandom_range(0, 199) == 0);
            axis_sel_val = 2'($urandom);
            lvl_wr = ($urandom_range(0, 299) == 0);
            lvl_val = 6'($urandom_range(0, 34));
            cyc("R7");
        end
        clear_in();
        cyc("R9");

        summary();
        $finish;
    end
endmodule